// File: doc/BRIEF.md
# Stream Broadcaster with Lane Remap

This block takes one AXI4-Stream source and presents each of its beats on several AXI4-Stream sinks at once. Each sink does not see the whole input word. It sees a narrow byte slice picked by a parameter. With the default settings a 24-bit pixel word becomes three 8-bit colour streams: sink 0 gets bits [7:0], sink 1 gets bits [15:8] and sink 2 gets bits [23:16]. The last-beat flag and the user sideband go unchanged to every sink next to its slice.

The sinks may stall independently of one another. The block keeps a small state machine per sink that records whether that sink has already taken the current beat. A sink that has taken the beat sees its valid drop until the source beat is consumed, so it never receives the same beat twice. The source beat is consumed only when every sink has either taken it earlier or is taking it in the current cycle. The block holds no data of its own: slices and sideband pass straight from the input to the outputs.

Each lane state machine has two states. OFFER means the lane has not yet taken the current beat, and its valid follows the input valid. DONE means the lane has taken the beat and its valid is held low. The transitions are named as follows:
- take: OFFER to DONE, when the lane's handshake completes while the input beat is not consumed in the same cycle.
- release: DONE to OFFER, when the input handshake completes.
- In every other case the lane stays in its state. A lane handshake in the same cycle as the input handshake leaves the lane in OFFER.

Top module: `strm_fanout_remap`

## Requirements
- R1: After reset every lane is in OFFER. With s_valid high, every m_valid bit is high. With s_valid low and all m_ready high, s_ready is high.
- R2: Lane k drives m_data[8k+7:8k] with s_data[L+7:L], where L is the lane's LSB parameter. The defaults are L=0, 8 and 16 for lanes 0, 1 and 2.
- R3: m_last[k] equals s_last and m_user[k] equals s_user on every lane.
- R4: m_valid[k] is high only while s_valid is high, and it is high whenever lane k has not yet taken the current beat.
- R5: s_ready is high exactly when every lane either has m_ready high or has already taken the current beat.
- R6: A lane that completes its handshake while s_ready is low holds m_valid low from the next cycle until the input beat is consumed. The other lanes are not affected.
- R7: After an input handshake every lane is back in OFFER, so a new beat is offered on all lanes in the next cycle.
- R8: Under independent backpressure on each lane, every lane receives every input beat exactly once, in order, with the correct slice and sideband.
- R9: While s_valid is low, all m_valid bits are low whatever m_ready is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Source beat accepted by all lanes |
| s_data | input | IN_W (24) | Source data word |
| s_last | input | 1 | Source last-beat flag |
| s_user | input | USER_W (1) | Source user sideband |
| m_valid | output | NUM_OUT (3) | Per-lane valid |
| m_ready | input | NUM_OUT (3) | Per-lane ready |
| m_data | output | NUM_OUT*OUT_W (24) | Per-lane sliced data, lane k at [8k+7:8k] |
| m_last | output | NUM_OUT (3) | Per-lane copy of s_last |
| m_user | output | NUM_OUT*USER_W (3) | Per-lane copy of s_user |

## Verification
The assertions check four things on every cycle. A lane valid never appears without the source valid. A lane stalled in OFFER with its ready low keeps the source ready low. A lane that completes its handshake while the source is stalled goes quiet in the next cycle. After a consumed beat, the next valid beat is offered on all lanes. Some properties can only be shown by the bench's scenarios, because they need a record of the beats sent: that the slice positions are correct, that the sideband is copied, and that under random per-lane backpressure each lane receives each beat exactly once and in order.

// File: rtl/strm_fanout_pkg.sv
package strm_fanout_pkg;

    typedef enum logic {
        LANE_OFFER = 1'b0,
        LANE_DONE  = 1'b1
    } lane_state_e;

endpackage

// File: rtl/strm_lane_ctrl.sv
module strm_lane_ctrl
    import strm_fanout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_valid,
    input  logic src_take,
    input  logic dst_ready,
    output logic dst_valid,
    output logic lane_clear
);

    lane_state_e state_q;
    lane_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_OFFER;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: take and release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_OFFER: begin
                if (src_valid && dst_ready && !src_take) begin
                    state_d = LANE_DONE;
                end
            end
            LANE_DONE: begin
                if (src_take) begin
                    state_d = LANE_OFFER;
                end
            end
            default: state_d = LANE_OFFER;
        endcase
    end

    // Outputs
    always_comb begin
        dst_valid  = 1'b0;
        lane_clear = dst_ready;
        unique case (state_q)
            LANE_OFFER: dst_valid = src_valid;
            LANE_DONE:  lane_clear = 1'b1;
            default:    dst_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/strm_ready_join.sv
module strm_ready_join #(
    parameter int NUM_OUT = 3
) (
    input  logic [NUM_OUT-1:0] lane_clear,
    output logic               all_clear
);

    always_comb begin
        all_clear = 1'b1;
        for (int k = 0; k < NUM_OUT; k++) begin
            all_clear = all_clear & lane_clear[k];
        end
    end

endmodule

// File: rtl/strm_fanout_remap.sv
module strm_fanout_remap #(
    parameter int                    NUM_OUT  = 3,
    parameter int                    IN_W     = 24,
    parameter int                    OUT_W    = 8,
    parameter int                    USER_W   = 1,
    parameter logic [NUM_OUT*8-1:0]  LANE_LSB = {8'd16, 8'd8, 8'd0}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_valid,
    output logic                      s_ready,
    input  logic [IN_W-1:0]           s_data,
    input  logic                      s_last,
    input  logic [USER_W-1:0]         s_user,
    output logic [NUM_OUT-1:0]        m_valid,
    input  logic [NUM_OUT-1:0]        m_ready,
    output logic [NUM_OUT*OUT_W-1:0]  m_data,
    output logic [NUM_OUT-1:0]        m_last,
    output logic [NUM_OUT*USER_W-1:0] m_user
);

    logic [NUM_OUT-1:0] lane_clear;
    logic               all_clear;
    logic               src_take;

    assign src_take = s_valid && all_clear;
    assign s_ready  = all_clear;

    strm_ready_join #(.NUM_OUT(NUM_OUT)) u_join (
        .lane_clear (lane_clear),
        .all_clear  (all_clear)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        localparam int LSB_K = int'(LANE_LSB[8*k +: 8]);

        strm_lane_ctrl u_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_valid  (s_valid),
            .src_take   (src_take),
            .dst_ready  (m_ready[k]),
            .dst_valid  (m_valid[k]),
            .lane_clear (lane_clear[k])
        );

        assign m_data[k*OUT_W +: OUT_W]   = s_data[LSB_K +: OUT_W];
        assign m_last[k]                  = s_last;
        assign m_user[k*USER_W +: USER_W] = s_user;
    end

endmodule

// File: rtl/strm_fanout_remap_chk.sv
module strm_fanout_remap_chk #(
    parameter int NUM_OUT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_valid,
    input logic               s_ready,
    input logic [NUM_OUT-1:0] m_valid,
    input logic [NUM_OUT-1:0] m_ready
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
        // R4
        valid_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_valid[k] |-> s_valid);

        // R5
        stalled_lane_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[k] && !m_ready[k]) |-> !s_ready);

        // R6
        taken_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[k] && m_ready[k] && !s_ready) |=> !m_valid[k]);
    end

    // R7
    all_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (!s_valid || (&m_valid)));

endmodule

bind strm_fanout_remap strm_fanout_remap_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready)
);

// File: tb/tb_strm_fanout_remap.sv
module tb_strm_fanout_remap;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_valid;
    logic        s_ready;
    logic [23:0] s_data;
    logic        s_last;
    logic [0:0]  s_user;
    logic [2:0]  m_valid;
    logic [2:0]  m_ready;
    logic [23:0] m_data;
    logic [2:0]  m_last;
    logic [2:0]  m_user;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strm_fanout_remap dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .s_data  (s_data),
        .s_last  (s_last),
        .s_user  (s_user),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_data  (m_data),
        .m_last  (m_last),
        .m_user  (m_user)
    );

    // {data[23:0], last, user, first-cycle ready pattern[2:0]}
    localparam logic [28:0] VEC [8] = '{
        {24'h112233, 1'b0, 1'b1, 3'b111},
        {24'hA5C3F0, 1'b1, 1'b0, 3'b000},
        {24'h00FF00, 1'b0, 1'b0, 3'b001},
        {24'hFF00FF, 1'b1, 1'b1, 3'b010},
        {24'h123456, 1'b0, 1'b1, 3'b100},
        {24'h89ABCD, 1'b1, 1'b0, 3'b011},
        {24'h7E817E, 1'b0, 1'b1, 3'b110},
        {24'hDEAD01, 1'b1, 1'b1, 3'b101}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] beat_word(input int j);
        return 24'(j * 40503 + 7);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        s_valid = 1'b0;
        s_data  = '0;
        s_last  = 1'b0;
        s_user  = '0;
        m_ready = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: idle after reset
        #1;
        check(m_valid == 3'b000, "R9 idle valid", 32'(m_valid), 0);
        check(s_ready == 1'b0, "R1 ready with no lane ready", 32'(s_ready), 0);
        m_ready = 3'b111;
        #1;
        check(s_ready == 1'b1, "R1 flags clear", 32'(s_ready), 1);
        m_ready = 3'b000;
        s_valid = 1'b1;
        s_data  = 24'h010203;
        #1;
        check(m_valid == 3'b111, "R1 all lanes offer", 32'(m_valid), 32'h7);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        #1;
        check(m_valid == 3'b000, "R9 valid low while no source", 32'(m_valid), 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        foreach (VEC[i]) begin
            logic [2:0] pat;
            @(negedge clk);
            pat     = VEC[i][2:0];
            s_valid = 1'b1;
            s_data  = VEC[i][28:5];
            s_last  = VEC[i][4];
            s_user  = VEC[i][3];
            m_ready = pat;
            #1;
            check(m_valid == 3'b111, "R4 R7 fresh beat on all lanes", 32'(m_valid), 32'h7);
            for (int k = 0; k < 3; k++) begin
                check(m_data[8*k +: 8] == s_data[8*k +: 8], "R2 lane slice",
                      32'(m_data[8*k +: 8]), 32'(VEC[i][5+8*k +: 8]));
                check(m_last[k] == VEC[i][4] && m_user[k] == VEC[i][3], "R3 sideband",
                      32'({m_last[k], m_user[k]}), 32'(VEC[i][4:3]));
            end
            check(s_ready == (pat == 3'b111), "R5 ready vs lane readies", 32'(s_ready), 32'(pat == 3'b111));
            if (pat != 3'b111) begin
                @(posedge clk);
                @(negedge clk);
                m_ready = 3'b111;
                #1;
                check(m_valid == ~pat, "R6 taken lanes quiet", 32'(m_valid), 32'(~pat));
                check(s_ready == 1'b1, "R5 ready after remaining lanes", 32'(s_ready), 1);
            end
            @(posedge clk);
        end

        // Directed staggered acceptance: R5 R6
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = 24'hCAFE42;
        m_ready = 3'b001;
        #1;
        check(s_ready == 1'b0, "R5 one of three ready", 32'(s_ready), 0);
        @(posedge clk);
        @(negedge clk);
        m_ready = 3'b100;
        #1;
        check(m_valid == 3'b110, "R6 lane0 quiet", 32'(m_valid), 32'h6);
        check(s_ready == 1'b0, "R5 lane1 still pending", 32'(s_ready), 0);
        @(posedge clk);
        @(negedge clk);
        m_ready = 3'b000;
        #1;
        check(m_valid == 3'b010, "R6 lanes0 and 2 quiet", 32'(m_valid), 32'h2);
        @(posedge clk);
        @(negedge clk);
        m_ready = 3'b010;
        #1;
        check(s_ready == 1'b1, "R5 last lane completes", 32'(s_ready), 1);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        m_ready = 3'b111;
        #1;
        check(m_valid == 3'b000, "R9 no source with ready lanes", 32'(m_valid), 0);
        s_valid = 1'b1;
        #1;
        check(m_valid == 3'b111, "R7 reoffer after consume", 32'(m_valid), 32'h7);
        @(negedge clk);
        s_valid = 1'b0;
        @(posedge clk);

        // Random per-lane backpressure: R8
        begin
            int  sent = 0;
            int  rx[3] = '{0, 0, 0};
            bit  took = 1'b0;
            int  guard = 0;
            while (sent < N_RAND && guard < 20000) begin
                @(negedge clk);
                guard++;
                if (took) begin
                    s_valid = 1'b0;
                    took    = 1'b0;
                end
                m_ready = 3'($urandom);
                if (!s_valid && ($urandom % 4 != 0)) begin
                    s_valid = 1'b1;
                    s_data  = beat_word(sent);
                    s_last  = (sent % 5 == 4);
                    s_user  = 1'(sent % 7 == 0);
                end
                #1;
                for (int k = 0; k < 3; k++) begin
                    if (m_valid[k] && m_ready[k]) begin
                        logic [23:0] w;
                        w = beat_word(rx[k]);
                        check(rx[k] == sent, "R8 exactly once in order", 32'(rx[k]), 32'(sent));
                        check(m_data[8*k +: 8] == w[8*k +: 8] && m_last[k] == (rx[k] % 5 == 4),
                              "R8 slice and last", 32'({m_last[k], m_data[8*k +: 8]}),
                              32'({rx[k] % 5 == 4, w[8*k +: 8]}));
                        rx[k]++;
                    end
                end
                took = s_valid && s_ready;
                @(posedge clk);
                if (took) sent++;
            end
            for (int k = 0; k < 3; k++) begin
                check(rx[k] == N_RAND, "R8 beat count per lane", 32'(rx[k]), 32'(N_RAND));
            end
        end

        @(negedge clk);
        s_valid = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule